// File: doc/BRIEF.md
# Exception and Interrupt State Coprocessor

This block keeps the exception state of a 32-bit processor core. It has four software-visible registers, each selected by a five-bit register number: the faulting data address, the status word, the cause word and the exception return address. The core reads one register at a time through a combinational read port and writes through a write strobe. It also reports three events to the block: a synchronous exception with its code, the address of the instruction in flight, and a return-from-exception strobe.

Eight level-sensitive interrupt lines are sampled into pending bits every cycle. An interrupt request goes to the core whenever an unmasked pending bit meets an enabled current interrupt-enable bit. The block takes such an interrupt by itself on the next clock edge. Exception entry, whether synchronous or from an interrupt, pushes a six-bit stack of mode and enable pairs. Return pops that stack.

Each cycle is classified into exactly one event by a priority arbiter. The events are: `EV_IDLE` (nothing happens), `EV_SYNC` (synchronous exception entry), `EV_INTR` (interrupt entry), `EV_RFE` (return from exception) and `EV_WRITE` (software register write). The priority is `EV_SYNC` over `EV_INTR` over `EV_RFE` over `EV_WRITE`. Every register updates from a `unique case` on that event, so each transition is a named event.

Top module: `sysctl_cop`

## Requirements
- R1: After reset, registers 8, 12, 13 and 14 all read 0 and `irq_out` is 0.
- R2: Register number 8 is the bad address, 12 the status word, 13 the cause word and 14 the return address. Any other number reads 0.
- R3: Status keeps the interrupt mask in bits [15:8] and the stack in bits [5:0]. The stack bits are: bit0 current enable, bit1 current user mode, bit2 previous enable, bit3 previous user mode, bit4 old enable, bit5 old user mode. A write to 12 stores only those fields, and the rest read 0. A write to 14 stores all 32 bits. Writes to 8 and 13 change nothing.
- R4: Cause bits [15:8] show the interrupt lines as sampled at the previous clock edge.
- R5: `irq_out` is 1 exactly when (pending AND mask) is non-zero and the current enable bit is 1.
- R6: On any exception entry, the stack moves left by two: current goes to previous, previous goes to old, and the new current pair becomes 00.
- R7: On a synchronous exception, Cause bits [6:2] take `exc_code` and register 14 takes `exc_pc`. The code values are: 0 interrupt, 4 load or fetch address error, 5 store address error, 6 fetch bus error, 7 data bus error, 8 system call, 9 breakpoint, 10 reserved instruction, 12 overflow.
- R8: Register 8 loads `exc_badaddr` only on a synchronous exception with code 4 or 5. Otherwise it holds its value.
- R9: When `irq_out` is 1 and no synchronous exception is requested, the next edge takes an interrupt: the code becomes 0 and register 14 takes `exc_pc`.
- R10: A synchronous exception in the same cycle as a pending interrupt records the synchronous code.
- R11: Return from exception moves the stack right by two, leaves the old pair as it was, and does not touch the mask.
- R12: Exception entry wins over a return strobe and a register write in the same cycle. A return wins over a write in the same cycle, and that write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | 8 | Interrupt level inputs |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | 5 | Code of the synchronous exception |
| exc_pc | input | 32 | Address of the instruction in flight |
| exc_badaddr | input | 32 | Faulting data address |
| rfe | input | 1 | Return-from-exception strobe |
| wr_en | input | 1 | Register write strobe |
| reg_num | input | 5 | Register number for read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected register |
| irq_out | output | 1 | Interrupt request to the core |

## Verification
Several properties are checked on every cycle:
- the stack push on entry and the stack pop on return;
- the code and return address captured on each kind of entry;
- the bad address holding its value outside address errors;
- pending bits following the lines;
- the request dropping right after any entry;
- entry beating return.

Other behaviour can only be shown by the directed scenarios. These cover the register-number map and the read-as-zero fields, ignored writes to registers 8 and 13, mask blocking, the automatic interrupt take, and the drop of a write when a return or an entry coincides with it.

// File: rtl/sysctl_pkg.sv
`timescale 1ns/1ps
package sysctl_pkg;
    typedef enum logic [2:0] {
        EV_IDLE,
        EV_SYNC,
        EV_INTR,
        EV_RFE,
        EV_WRITE
    } sc_event_e;

    localparam int STK_W     = 6;
    localparam int MASK_LSB  = 8;
    localparam int CODE_LSB  = 2;

    localparam logic [4:0] RN_BADVA  = 5'd8;
    localparam logic [4:0] RN_STATUS = 5'd12;
    localparam logic [4:0] RN_CAUSE  = 5'd13;
    localparam logic [4:0] RN_EPC    = 5'd14;

    localparam logic [4:0] CODE_INT  = 5'd0;
    localparam logic [4:0] CODE_ADEL = 5'd4;
    localparam logic [4:0] CODE_ADES = 5'd5;
endpackage

// File: rtl/sysctl_arb.sv
`timescale 1ns/1ps
module sysctl_arb
    import sysctl_pkg::*;
(
    input  logic      exc_req,
    input  logic      irq_req,
    input  logic      rfe,
    input  logic      wr_en,
    output sc_event_e ev
);
    // Fixed priority: synchronous > interrupt > return > write (R10, R12)
    always_comb begin
        if (exc_req)      ev = EV_SYNC;
        else if (irq_req) ev = EV_INTR;
        else if (rfe)     ev = EV_RFE;
        else if (wr_en)   ev = EV_WRITE;
        else              ev = EV_IDLE;
    end
endmodule

// File: rtl/sysctl_status.sv
`timescale 1ns/1ps
module sysctl_status
    import sysctl_pkg::*;
#(
    parameter int IRQ_N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sc_event_e        ev,
    input  logic             wr_sel,
    input  logic [IRQ_N-1:0] wr_mask,
    input  logic [STK_W-1:0] wr_stk,
    output logic [IRQ_N-1:0] mask,
    output logic [STK_W-1:0] stk,
    output logic             ie_cur
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '0;
            stk  <= '0;
        end else begin
            unique case (ev)
                EV_SYNC, EV_INTR: stk <= {stk[3:0], 2'b00};
                EV_RFE:           stk <= {stk[5:4], stk[5:2]};
                EV_WRITE: begin
                    if (wr_sel) begin
                        mask <= wr_mask;
                        stk  <= wr_stk;
                    end
                end
                EV_IDLE: begin end
            endcase
        end
    end

    assign ie_cur = stk[0];

    assert_entry_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_SYNC || ev == EV_INTR) |=>
            (stk[1:0] == 2'b00 && stk[3:2] == $past(stk[1:0]) && stk[5:4] == $past(stk[3:2])));

    assert_rfe_keeps_old_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_RFE) |=>
            (stk[5:4] == $past(stk[5:4]) && stk[3:2] == $past(stk[5:4]) && stk[1:0] == $past(stk[3:2])));

    assert_mask_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != EV_WRITE) |=> $stable(mask));
endmodule

// File: rtl/sysctl_cause.sv
`timescale 1ns/1ps
module sysctl_cause
    import sysctl_pkg::*;
#(
    parameter int IRQ_N  = 8,
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sc_event_e         ev,
    input  logic [IRQ_N-1:0]  irq_lines,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [IRQ_N-1:0]  mask,
    input  logic              ie_cur,
    output logic [IRQ_N-1:0]  pending,
    output logic [CODE_W-1:0] code,
    output logic              irq_req
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= '0;
            code    <= '0;
        end else begin
            pending <= irq_lines;
            unique case (ev)
                EV_SYNC:  code <= exc_code;
                EV_INTR:  code <= CODE_W'(CODE_INT);
                EV_RFE, EV_WRITE, EV_IDLE: begin end
            endcase
        end
    end

    assign irq_req = ie_cur & (|(pending & mask));

    assert_pending_track_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pending == $past(irq_lines)));

    assert_sync_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_SYNC) |=> (code == $past(exc_code)));

    assert_intr_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_INTR) |=> (code == '0));
endmodule

// File: rtl/sysctl_addr.sv
`timescale 1ns/1ps
module sysctl_addr
    import sysctl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sc_event_e         ev,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [DATA_W-1:0] exc_pc,
    input  logic [DATA_W-1:0] exc_badaddr,
    input  logic              wr_epc,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] epc,
    output logic [DATA_W-1:0] badva
);
    logic addr_err;
    assign addr_err = (exc_code == CODE_W'(CODE_ADEL)) || (exc_code == CODE_W'(CODE_ADES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            epc   <= '0;
            badva <= '0;
        end else begin
            unique case (ev)
                EV_SYNC: begin
                    epc <= exc_pc;
                    if (addr_err) badva <= exc_badaddr;
                end
                EV_INTR:  epc <= exc_pc;
                EV_WRITE: if (wr_epc) epc <= wr_data;
                EV_RFE, EV_IDLE: begin end
            endcase
        end
    end

    assert_epc_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_SYNC || ev == EV_INTR) |=> (epc == $past(exc_pc)));

    assert_badva_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != EV_SYNC || !addr_err) |=> $stable(badva));
endmodule

// File: rtl/sysctl_cop.sv
`timescale 1ns/1ps
module sysctl_cop
    import sysctl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IRQ_N  = 8,
    parameter int CODE_W = 5,
    parameter int RN_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IRQ_N-1:0]  irq_lines,
    input  logic              exc_req,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [DATA_W-1:0] exc_pc,
    input  logic [DATA_W-1:0] exc_badaddr,
    input  logic              rfe,
    input  logic              wr_en,
    input  logic [RN_W-1:0]   reg_num,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_out
);
    localparam int MASK_MSB = MASK_LSB + IRQ_N - 1;

    sc_event_e         ev;
    logic [IRQ_N-1:0]  mask;
    logic [STK_W-1:0]  stk;
    logic              ie_cur;
    logic [IRQ_N-1:0]  pending;
    logic [CODE_W-1:0] code;
    logic              irq_req;
    logic [DATA_W-1:0] epc;
    logic [DATA_W-1:0] badva;
    logic              wr_status;
    logic              wr_epc;

    assign wr_status = wr_en && (reg_num == RN_W'(RN_STATUS));
    assign wr_epc    = wr_en && (reg_num == RN_W'(RN_EPC));

    sysctl_arb u_arb (
        .exc_req (exc_req),
        .irq_req (irq_req),
        .rfe     (rfe),
        .wr_en   (wr_en),
        .ev      (ev)
    );

    sysctl_status #(.IRQ_N(IRQ_N)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .wr_sel  (wr_status),
        .wr_mask (wr_data[MASK_MSB:MASK_LSB]),
        .wr_stk  (wr_data[STK_W-1:0]),
        .mask    (mask),
        .stk     (stk),
        .ie_cur  (ie_cur)
    );

    sysctl_cause #(.IRQ_N(IRQ_N), .CODE_W(CODE_W)) u_cause (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .irq_lines (irq_lines),
        .exc_code  (exc_code),
        .mask      (mask),
        .ie_cur    (ie_cur),
        .pending   (pending),
        .code      (code),
        .irq_req   (irq_req)
    );

    sysctl_addr #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev          (ev),
        .exc_code    (exc_code),
        .exc_pc      (exc_pc),
        .exc_badaddr (exc_badaddr),
        .wr_epc      (wr_epc),
        .wr_data     (wr_data),
        .epc         (epc),
        .badva       (badva)
    );

    // Read mux; unused bits are zero (R2, R3)
    always_comb begin
        rd_data = '0;
        if (reg_num == RN_W'(RN_BADVA)) begin
            rd_data = badva;
        end else if (reg_num == RN_W'(RN_STATUS)) begin
            rd_data[MASK_MSB:MASK_LSB] = mask;
            rd_data[STK_W-1:0]         = stk;
        end else if (reg_num == RN_W'(RN_CAUSE)) begin
            rd_data[MASK_MSB:MASK_LSB]          = pending;
            rd_data[CODE_LSB+CODE_W-1:CODE_LSB] = code;
        end else if (reg_num == RN_W'(RN_EPC)) begin
            rd_data = epc;
        end
    end

    assign irq_out = irq_req;

    assert_entry_drops_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_SYNC || ev == EV_INTR) |=> !irq_out);

    assert_entry_beats_rfe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && rfe) |=> (stk[1:0] == 2'b00));
endmodule

// File: tb/sysctl_cop_tb_top.sv
`timescale 1ns/1ps
module sysctl_cop_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq_lines = '0;
    logic        exc_req = 1'b0;
    logic [4:0]  exc_code = '0;
    logic [31:0] exc_pc = '0;
    logic [31:0] exc_badaddr = '0;
    logic        rfe = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  reg_num = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sysctl_cop dut_i (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .exc_req(exc_req),
        .exc_code(exc_code), .exc_pc(exc_pc), .exc_badaddr(exc_badaddr),
        .rfe(rfe), .wr_en(wr_en), .reg_num(reg_num), .wr_data(wr_data),
        .rd_data(rd_data), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd_chk(input string req, input logic [4:0] num, input logic [31:0] exp);
        reg_num = num;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic wr(input logic [4:0] num, input logic [31:0] d);
        wr_en = 1'b1; reg_num = num; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        rd_chk("R1 badva", 5'd8, 32'h0);
        rd_chk("R1 status", 5'd12, 32'h0);
        rd_chk("R1 cause", 5'd13, 32'h0);
        rd_chk("R1 epc", 5'd14, 32'h0);
        check("R1 irq_out", {31'h0, irq_out}, 32'h0);
        rd_chk("R2 unmapped reg 3", 5'd3, 32'h0);
    endtask

    task automatic t_writes();
        wr(5'd12, 32'hFFFF_FF3F);
        rd_chk("R3 status fields", 5'd12, 32'h0000_FF3F);
        wr(5'd14, 32'hDEAD_BEEF);
        rd_chk("R3 epc full write", 5'd14, 32'hDEAD_BEEF);
        wr(5'd8, 32'h0000_1234);
        rd_chk("R3 badva write ignored", 5'd8, 32'h0);
        wr(5'd13, 32'hFFFF_FFFF);
        rd_chk("R3 cause write ignored", 5'd13, 32'h0);
        wr(5'd9, 32'hFFFF_FFFF);
        rd_chk("R2 reg 9 reads zero", 5'd9, 32'h0);
        rd_chk("R2 status unchanged by reg 9 write", 5'd12, 32'h0000_FF3F);
    endtask

    task automatic t_sync();
        wr(5'd12, 32'h0000_000E);
        exc_req = 1'b1; exc_code = 5'd8; exc_pc = 32'h0040_0100; exc_badaddr = 32'h999;
        tick();
        exc_req = 1'b0;
        rd_chk("R6 stack push", 5'd12, 32'h0000_0038);
        rd_chk("R7 syscall code", 5'd13, 32'h0000_0020);
        rd_chk("R7 epc capture", 5'd14, 32'h0040_0100);
        rd_chk("R8 badva held for code 8", 5'd8, 32'h0);
        exc_req = 1'b1; exc_code = 5'd5; exc_pc = 32'h0040_0200; exc_badaddr = 32'hABCD_0003;
        tick();
        exc_req = 1'b0;
        rd_chk("R8 badva on store address error", 5'd8, 32'hABCD_0003);
        rd_chk("R6 second push", 5'd12, 32'h0000_0020);
        rd_chk("R7 store address code", 5'd13, 32'h0000_0014);
    endtask

    task automatic t_rfe();
        wr(5'd12, 32'h0000_A52D);
        rfe = 1'b1;
        tick();
        rfe = 1'b0;
        rd_chk("R11 pop keeps old and mask", 5'd12, 32'h0000_A52B);
    endtask

    task automatic t_intr();
        wr(5'd12, 32'h0000_0000);
        irq_lines = 8'h04;
        tick();
        rd_chk("R4 pending shows line 2", 5'd13, 32'h0000_0414);
        check("R5 no request while disabled", {31'h0, irq_out}, 32'h0);
        wr(5'd12, 32'h0000_0801);
        check("R5 masked level blocked", {31'h0, irq_out}, 32'h0);
        exc_pc = 32'h0040_0300;
        wr(5'd12, 32'h0000_0401);
        check("R5 request raised", {31'h0, irq_out}, 32'h1);
        tick();
        rd_chk("R9 interrupt code 0", 5'd13, 32'h0000_0400);
        rd_chk("R9 epc on interrupt", 5'd14, 32'h0040_0300);
        rd_chk("R6 push on interrupt", 5'd12, 32'h0000_0404);
        check("R5 request dropped after entry", {31'h0, irq_out}, 32'h0);
    endtask

    task automatic t_collide();
        wr(5'd12, 32'h0000_0401);
        check("R5 request raised again", {31'h0, irq_out}, 32'h1);
        exc_req = 1'b1; exc_code = 5'd12; exc_pc = 32'h0040_0400;
        tick();
        exc_req = 1'b0;
        rd_chk("R10 sync code wins", 5'd13, 32'h0000_0430);
        rd_chk("R10 epc of sync", 5'd14, 32'h0040_0400);
        irq_lines = 8'h00;
        tick();
        tick();
        exc_req = 1'b1; exc_code = 5'd9; exc_pc = 32'h0040_0500;
        rfe = 1'b1; wr_en = 1'b1; reg_num = 5'd12; wr_data = 32'h0;
        tick();
        exc_req = 1'b0; rfe = 1'b0; wr_en = 1'b0;
        rd_chk("R12 entry beats return and write", 5'd12, 32'h0000_0410);
        rd_chk("R12 breakpoint code", 5'd13, 32'h0000_0024);
        rfe = 1'b1; wr_en = 1'b1; reg_num = 5'd14; wr_data = 32'h1111_1111;
        tick();
        rfe = 1'b0; wr_en = 1'b0;
        rd_chk("R12 return applied", 5'd12, 32'h0000_0414);
        rd_chk("R12 write dropped under return", 5'd14, 32'h0040_0500);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_writes();
        t_sync();
        t_rfe();
        t_intr();
        t_collide();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule